// File: doc/BRIEF.md
# Descriptor Table Base Register Loader

This block holds the two table-pointer registers of a processor core. One register points at the global descriptor table and the other at the interrupt table. Each register pairs a 16-bit limit with a 64-bit base. The core issues a load request with the following fields:

- a select bit that picks the register;
- an 80-bit source image already fetched from memory;
- an operand-size code;
- the qualifiers the decoder already knows: whether the operand was a memory location, the privilege level, the processor mode and whether a lock prefix was present.

Segment-limit, canonical-address and paging checks are done elsewhere. Their result arrives as one external fault flag with its vector.

The loader decides within the request cycle. On the next clock edge it does one of two things:

- It writes the chosen register and pulses `done_o`.
- It leaves both registers alone and pulses `fault_o` with one vector on `fault_code_o`.

Both registers are always visible on the output ports. A new request may be presented on every cycle.

Top module: `dtr_loader`

## Requirements
- R1: After reset both limits read 0xFFFF, both bases read 0, and `done_o`, `fault_o` and `fault_code_o` are 0.
- R2: A successful load writes the limit from source bits 15:0 for every operand size.
- R3: Size code 0 (16-bit) outside mode 3 writes a base equal to source bits 39:16, zero-extended. This is source bits 47:16 masked with 0x00FFFFFF.
- R4: Size code 1 (32-bit) outside mode 3 writes base bits 31:0 from source bits 47:16 and clears base bits 63:32.
- R5: In mode 3 (64-bit mode) the operand width is fixed. Size codes 0, 1 and 2 all write the base from source bits 79:16.
- R6: `req_sel` 0 loads the global register and `req_sel` 1 loads the interrupt register. The other register keeps its value.
- R7: Any of the following faults with vector 6 (undefined opcode):
  - the operand is not in memory (`req_is_mem` 0);
  - a lock prefix in mode 0 (real), mode 2 (virtual-8086) or mode 3;
  - size code 3;
  - size code 2 outside mode 3.
- R8: Any of the following faults with vector 13 (general protection):
  - a lock prefix in mode 1 (protected);
  - every request in mode 2;
  - a privilege level other than 0 in mode 1 or mode 3.

  In mode 0 the privilege level is ignored.
- R9: When several faults apply, vector 6 wins over vector 13, and vector 13 wins over the external fault. The external fault reports `req_ext_code` unchanged.
- R10: A faulting request changes neither register.
- R11: The loader answers one cycle after each valid request. It raises exactly one of `done_o` and `fault_o` for one cycle. When no request was valid it raises neither. `fault_code_o` is 0 whenever `fault_o` is low.
- R12: Requests on consecutive cycles are each handled in turn. The later one sees the register contents left by the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present this cycle |
| req_sel | input | 1 | 0 global register, 1 interrupt register |
| req_src | input | 80 | Source image: limit in 15:0, base above it |
| req_size | input | 2 | 0 = 16-bit, 1 = 32-bit, 2 = 64-bit, 3 = reserved |
| req_is_mem | input | 1 | Operand was a memory location |
| req_cpl | input | 2 | Current privilege level |
| req_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 64-bit |
| req_lock | input | 1 | Lock prefix present |
| req_ext_fault | input | 1 | Fault reported by address and paging checks |
| req_ext_code | input | 4 | Vector of the external fault |
| done_o | output | 1 | One-cycle pulse: register loaded |
| fault_o | output | 1 | One-cycle pulse: request rejected |
| fault_code_o | output | 4 | Vector of the rejection, 0 otherwise |
| gdt_limit_o | output | 16 | Global register limit |
| gdt_base_o | output | 64 | Global register base |
| idt_limit_o | output | 16 | Interrupt register limit |
| idt_base_o | output | 64 | Interrupt register base |

## Verification
The bound assertions check, on every cycle, the properties that hold however the registers were loaded:

- `done_o` and `fault_o` are never high together;
- an idle cycle produces no response;
- the fault vector is zero outside a fault;
- both registers hold whenever no load completes;
- a non-memory operand always gives vector 6;
- a plain virtual-8086 request always gives vector 13;
- an otherwise clean external fault is forwarded.

The base masking and widening for each size and mode, the select routing, and the full fault-priority ordering depend on the data and history. Only the bench's directed scenarios show them, together with its per-cycle reference model.

// File: rtl/dtr_loader.sv
module dtr_loader #(
  parameter int LIMIT_W = 16,
  parameter int BASE_W  = 64,
  parameter int CODE_W  = 4,
  parameter logic [CODE_W-1:0] UD_VEC = 4'd6,
  parameter logic [CODE_W-1:0] GP_VEC = 4'd13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_sel,
  input  logic [LIMIT_W+BASE_W-1:0] req_src,
  input  logic [1:0]           req_size,
  input  logic                 req_is_mem,
  input  logic [1:0]           req_cpl,
  input  logic [1:0]           req_mode,
  input  logic                 req_lock,
  input  logic                 req_ext_fault,
  input  logic [CODE_W-1:0]    req_ext_code,
  output logic                 done_o,
  output logic                 fault_o,
  output logic [CODE_W-1:0]    fault_code_o,
  output logic [LIMIT_W-1:0]   gdt_limit_o,
  output logic [BASE_W-1:0]    gdt_base_o,
  output logic [LIMIT_W-1:0]   idt_limit_o,
  output logic [BASE_W-1:0]    idt_base_o
);
  localparam int NARROW_W = 32;
  localparam int MASKED_W = 24;
  localparam logic [1:0] M_REAL = 2'd0, M_PROT = 2'd1, M_V86 = 2'd2, M_LONG = 2'd3;
  localparam logic [1:0] SZ_16 = 2'd0, SZ_32 = 2'd1, SZ_64 = 2'd2, SZ_RSV = 2'd3;

  logic wide_mode, ud_hit, gp_hit, any_fault;
  logic [CODE_W-1:0] vec_sel;
  logic [BASE_W-1:0] base_new;
  logic [LIMIT_W-1:0] limit_new;

  assign wide_mode = req_mode == M_LONG;

  assign ud_hit = !req_is_mem
               || (req_lock && req_mode != M_PROT)
               || req_size == SZ_RSV
               || (req_size == SZ_64 && !wide_mode);

  assign gp_hit = (req_lock && req_mode == M_PROT)
               || req_mode == M_V86
               || (req_cpl != 2'd0 && (req_mode == M_PROT || wide_mode));

  assign any_fault = ud_hit || gp_hit || req_ext_fault;
  assign vec_sel   = ud_hit ? UD_VEC : gp_hit ? GP_VEC : req_ext_code;
  assign limit_new = req_src[LIMIT_W-1:0];

  always_comb begin
    if (wide_mode || req_size == SZ_64)
      base_new = req_src[LIMIT_W +: BASE_W];
    else if (req_size == SZ_32)
      base_new = {{(BASE_W-NARROW_W){1'b0}}, req_src[LIMIT_W +: NARROW_W]};
    else
      base_new = {{(BASE_W-MASKED_W){1'b0}}, req_src[LIMIT_W +: MASKED_W]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o       <= 1'b0;
      fault_o      <= 1'b0;
      fault_code_o <= '0;
      gdt_limit_o  <= '1;
      gdt_base_o   <= '0;
      idt_limit_o  <= '1;
      idt_base_o   <= '0;
    end else begin
      done_o       <= req_valid && !any_fault;
      fault_o      <= req_valid && any_fault;
      fault_code_o <= (req_valid && any_fault) ? vec_sel : '0;
      if (req_valid && !any_fault) begin
        if (req_sel) begin
          idt_limit_o <= limit_new;
          idt_base_o  <= base_new;
        end else begin
          gdt_limit_o <= limit_new;
          gdt_base_o  <= base_new;
        end
      end
    end
  end
endmodule

// File: rtl/dtr_loader_props.sv
module dtr_loader_props #(
  parameter int LIMIT_W = 16,
  parameter int BASE_W  = 64,
  parameter int CODE_W  = 4,
  parameter logic [CODE_W-1:0] UD_VEC = 4'd6,
  parameter logic [CODE_W-1:0] GP_VEC = 4'd13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_size,
  input logic               req_is_mem,
  input logic [1:0]         req_cpl,
  input logic [1:0]         req_mode,
  input logic               req_lock,
  input logic               req_ext_fault,
  input logic [CODE_W-1:0]  req_ext_code,
  input logic               done_o,
  input logic               fault_o,
  input logic [CODE_W-1:0]  fault_code_o,
  input logic [LIMIT_W-1:0] gdt_limit_o,
  input logic [BASE_W-1:0]  gdt_base_o,
  input logic [LIMIT_W-1:0] idt_limit_o,
  input logic [BASE_W-1:0]  idt_base_o
);
  p_excl_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fault_o));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!done_o && !fault_o));

  p_code_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_o |-> fault_code_o == '0);

  p_not_mem_ud_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_mem) |=> (fault_o && fault_code_o == UD_VEC));

  p_v86_gp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_mem && !req_lock && req_mode == 2'd2 && req_size < 2'd2)
      |=> (fault_o && fault_code_o == GP_VEC));

  p_ext_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_mem && !req_lock && req_mode == 2'd1 && req_cpl == 2'd0
     && req_size < 2'd2 && req_ext_fault)
      |=> (fault_o && fault_code_o == $past(req_ext_code)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(gdt_limit_o) && $stable(gdt_base_o)
                 && $stable(idt_limit_o) && $stable(idt_base_o)));
endmodule

bind dtr_loader dtr_loader_props #(
  .LIMIT_W(LIMIT_W), .BASE_W(BASE_W), .CODE_W(CODE_W), .UD_VEC(UD_VEC), .GP_VEC(GP_VEC)
) u_props (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
  .req_is_mem(req_is_mem), .req_cpl(req_cpl), .req_mode(req_mode), .req_lock(req_lock),
  .req_ext_fault(req_ext_fault), .req_ext_code(req_ext_code),
  .done_o(done_o), .fault_o(fault_o), .fault_code_o(fault_code_o),
  .gdt_limit_o(gdt_limit_o), .gdt_base_o(gdt_base_o),
  .idt_limit_o(idt_limit_o), .idt_base_o(idt_base_o)
);

// File: tb/dtr_loader_tb_top.sv
module dtr_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_sel = 1'b0, req_is_mem = 1'b1, req_lock = 1'b0, req_ext_fault = 1'b0;
  logic [79:0] req_src = '0;
  logic [1:0] req_size = '0, req_cpl = '0, req_mode = 2'd1;
  logic [3:0] req_ext_code = '0;
  logic done_o, fault_o;
  logic [3:0] fault_code_o;
  logic [15:0] gdt_limit_o, idt_limit_o;
  logic [63:0] gdt_base_o, idt_base_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dtr_loader dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel), .req_src(req_src),
    .req_size(req_size), .req_is_mem(req_is_mem), .req_cpl(req_cpl), .req_mode(req_mode),
    .req_lock(req_lock), .req_ext_fault(req_ext_fault), .req_ext_code(req_ext_code),
    .done_o(done_o), .fault_o(fault_o), .fault_code_o(fault_code_o),
    .gdt_limit_o(gdt_limit_o), .gdt_base_o(gdt_base_o),
    .idt_limit_o(idt_limit_o), .idt_base_o(idt_base_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [15:0] m_glim, m_ilim;
  logic [63:0] m_gbase, m_ibase;
  logic m_done, m_fault;
  logic [3:0] m_code;
  bit model_live = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_glim = 16'hFFFF; m_ilim = 16'hFFFF; m_gbase = 0; m_ibase = 0;
      m_done = 0; m_fault = 0; m_code = 0;
      model_live = 1;
    end else begin
      int vec;
      logic [63:0] b;
      m_done = 0; m_fault = 0; m_code = 0;
      if (req_valid) begin
        vec = 0;
        if (!req_is_mem) vec = 6;
        else if (req_size == 3) vec = 6;
        else if (req_size == 2 && req_mode != 3) vec = 6;
        else if (req_lock && req_mode != 1) vec = 6;
        else if (req_mode == 2) vec = 13;
        else if (req_lock) vec = 13;
        else if (req_cpl != 0 && req_mode != 0) vec = 13;
        else if (req_ext_fault) vec = int'(req_ext_code);
        if (vec != 0 || req_ext_fault) begin
          m_fault = 1; m_code = 4'(vec);
        end else begin
          m_done = 1;
          if (req_mode == 3 || req_size == 2) b = req_src[79:16];
          else if (req_size == 1) b = {32'h0, req_src[47:16]};
          else b = {32'h0, req_src[47:16] & 32'h00FF_FFFF};
          if (req_sel) begin m_ilim = req_src[15:0]; m_ibase = b; end
          else begin m_glim = req_src[15:0]; m_gbase = b; end
        end
      end
    end
  end

  always begin
    @(posedge clk);
    #2;
    if (model_live && rst_n) begin
      chk("R11 done", done_o, m_done);
      chk("R11 fault", fault_o, m_fault);
      chk("R9 code", fault_code_o, m_code);
      chk("R2 gdt limit", gdt_limit_o, m_glim);
      chk("R6 gdt base", gdt_base_o, m_gbase);
      chk("R2 idt limit", idt_limit_o, m_ilim);
      chk("R6 idt base", idt_base_o, m_ibase);
    end
  end

  task automatic send(input logic sel, input logic [79:0] src, input logic [1:0] size,
                      input logic mem, input logic [1:0] cpl, input logic [1:0] mode,
                      input logic lock, input logic ext, input logic [3:0] ecode);
    @(negedge clk);
    req_valid = 1; req_sel = sel; req_src = src; req_size = size; req_is_mem = mem;
    req_cpl = cpl; req_mode = mode; req_lock = lock; req_ext_fault = ext; req_ext_code = ecode;
    @(negedge clk);
    req_valid = 0; req_ext_fault = 0; req_lock = 0; req_is_mem = 1;
  endtask

  localparam logic [79:0] SRC_A = 80'hAAAA_BBBB_CCDD_EEFF_1234;
  localparam logic [79:0] SRC_B = 80'h1111_2222_3333_4444_0F0F;

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 gdt limit", gdt_limit_o, 16'hFFFF);
    chk("R1 gdt base", gdt_base_o, 0);
    chk("R1 idt limit", idt_limit_o, 16'hFFFF);
    chk("R1 idt base", idt_base_o, 0);
    chk("R1 pulses", {done_o, fault_o, fault_code_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 idle", {done_o, fault_o}, 0);

    // R3 16-bit protected load of global register
    send(0, SRC_A, 2'd0, 1, 0, 2'd1, 0, 0, 0);
    chk("R3 done", done_o, 1);
    chk("R2 limit16", gdt_limit_o, 16'h1234);
    chk("R3 masked base", gdt_base_o, 64'h0000_0000_00DD_EEFF);
    chk("R6 idt untouched", idt_base_o, 0);

    // R4 32-bit load of interrupt register
    send(1, SRC_A, 2'd1, 1, 0, 2'd1, 0, 0, 0);
    chk("R4 idt base", idt_base_o, 64'h0000_0000_CCDD_EEFF);
    chk("R6 gdt kept", gdt_base_o, 64'h0000_0000_00DD_EEFF);

    // R5 64-bit in long mode, then R4 clears upper bits
    send(0, SRC_A, 2'd2, 1, 0, 2'd3, 0, 0, 0);
    chk("R5 full base", gdt_base_o, 64'hAAAA_BBBB_CCDD_EEFF);
    send(0, SRC_B, 2'd1, 1, 0, 2'd1, 0, 0, 0);
    chk("R4 upper cleared", gdt_base_o, 64'h0000_0000_3333_4444);
    chk("R2 limit32", gdt_limit_o, 16'h0F0F);
    send(1, SRC_B, 2'd0, 1, 0, 2'd3, 0, 0, 0);
    chk("R5 size0 long", idt_base_o, 64'h1111_2222_3333_4444);

    // R7 undefined-opcode cases, R10 registers kept
    send(0, SRC_A, 2'd1, 0, 0, 2'd1, 0, 0, 0);
    chk("R7 not mem", {fault_o, fault_code_o}, {1'b1, 4'd6});
    chk("R10 gdt kept", gdt_base_o, 64'h0000_0000_3333_4444);
    send(0, SRC_A, 2'd1, 1, 0, 2'd0, 1, 0, 0);
    chk("R7 lock real", fault_code_o, 4'd6);
    send(0, SRC_A, 2'd2, 1, 0, 2'd3, 1, 0, 0);
    chk("R7 lock long", fault_code_o, 4'd6);
    send(1, SRC_A, 2'd3, 1, 0, 2'd1, 0, 0, 0);
    chk("R7 size3", fault_code_o, 4'd6);
    send(1, SRC_A, 2'd2, 1, 0, 2'd1, 0, 0, 0);
    chk("R7 size64 prot", fault_code_o, 4'd6);
    chk("R10 idt kept", idt_base_o, 64'h1111_2222_3333_4444);

    // R8 general-protection cases
    send(0, SRC_A, 2'd1, 1, 0, 2'd1, 1, 0, 0);
    chk("R8 lock prot", fault_code_o, 4'd13);
    send(0, SRC_A, 2'd0, 1, 0, 2'd2, 0, 0, 0);
    chk("R8 v86", fault_code_o, 4'd13);
    send(0, SRC_A, 2'd1, 1, 3, 2'd1, 0, 0, 0);
    chk("R8 cpl3 prot", fault_code_o, 4'd13);
    send(0, SRC_A, 2'd2, 1, 1, 2'd3, 0, 0, 0);
    chk("R8 cpl1 long", fault_code_o, 4'd13);
    send(0, SRC_A, 2'd1, 1, 3, 2'd0, 0, 0, 0);
    chk("R8 real ignores cpl", {done_o, gdt_base_o}, {1'b1, 64'h0000_0000_CCDD_EEFF});

    // R9 priority
    send(0, SRC_B, 2'd1, 0, 3, 2'd2, 0, 1, 4'd14);
    chk("R9 ud over gp", fault_code_o, 4'd6);
    send(0, SRC_B, 2'd1, 1, 3, 2'd1, 0, 1, 4'd14);
    chk("R9 gp over ext", fault_code_o, 4'd13);
    send(0, SRC_B, 2'd1, 1, 0, 2'd1, 0, 1, 4'd12);
    chk("R9 ext forwarded", {fault_o, fault_code_o}, {1'b1, 4'd12});
    chk("R10 ext keeps", gdt_base_o, 64'h0000_0000_CCDD_EEFF);

    // R12 back to back
    @(negedge clk);
    req_valid = 1; req_sel = 0; req_src = SRC_B; req_size = 2'd1; req_mode = 2'd1; req_cpl = 0;
    @(negedge clk);
    chk("R12 first", {done_o, gdt_base_o}, {1'b1, 64'h0000_0000_3333_4444});
    req_sel = 1; req_src = SRC_A; req_size = 2'd0;
    @(negedge clk);
    chk("R12 second", {done_o, idt_base_o}, {1'b1, 64'h0000_0000_00DD_EEFF});
    req_valid = 0;
    @(negedge clk);
    chk("R11 one cycle", {done_o, fault_o}, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule